// File: doc/BRIEF.md
# Full-Search Block-Matching Motion Estimator

This block finds where one 16x16 block of 8-bit pixels best fits inside a 31x31 window of 8-bit pixels. The fit is measured as the sum of absolute pixel differences (SAD). Every one of the 256 candidate placements is tried: horizontal offsets 0 to 15 and vertical offsets 0 to 15, both measured from the top-left corner of the window. The block reports the lowest SAD together with the offset where it was found, which is the motion vector.

Before a search, software or a loader fills the two internal pixel stores through one write port. A one-cycle `start` pulse launches the search. Sixteen processing elements run in parallel, one for each horizontal offset. They accumulate their sums over 256 pixel cycles, and each such pass covers one vertical offset. After each pass, a combinational minimum selector picks the best of the sixteen sums. A tracker register keeps the best value seen over all passes. When the last pass ends, the result is latched to the outputs and `done` pulses.

The controller has four states. IDLE waits for `start`; start in IDLE moves to ACCUM. ACCUM adds one pixel pair per element per cycle; the last pixel moves to REDUCE. REDUCE compares the sixteen sums, updates the tracker and clears the sums; it moves back to ACCUM when passes remain and to FINISH after the last one. FINISH latches the results and always returns to IDLE. A synchronous reset forces IDLE from any state.

Top module: `sad_motion_search`

## Requirements
- R1: A write with `ld_en`=1 stores `ld_data` into one of two stores. With `ld_win`=0 it writes block pixel (row,col) at `ld_addr`=row*16+col, and only addresses below 256 are accepted. With `ld_win`=1 it writes window pixel (row,col) at `ld_addr`=row*31+col, and only addresses below 961 are accepted. A write to an address outside its store's range changes nothing.
- R2: `best_sad` is the minimum, over all x,y in 0..15, of the sum over r,c in 0..15 of |block[r][c] - window[y+r][x+c]|.
- R3: The SAD is exact up to its largest possible value of 65280 (all differences 255), with no wrap.
- R4: `mv_x` and `mv_y` give the x and y offsets of the winning candidate as unsigned values from 0 to 15.
- R5: When several candidates tie, the lowest y wins; among equal y, the lowest x wins.
- R6: `start` is accepted only while `busy`=0. `busy` goes high at the next edge. `done` is high for exactly one cycle, after the 4113th rising edge that follows the edge which sampled `start`. `busy` is low while `done` is high.
- R7: `best_sad`, `mv_x` and `mv_y` change only at the edge where `done` rises. They hold their values through any later search until that search's `done`.
- R8: A `start` pulse while `busy`=1 has no effect on the running search, its timing or its result.
- R9: A synchronous reset (`rst`=1 at a rising edge) returns the block to idle with `busy`=0, `done`=0 and all result outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Pixel write enable |
| ld_win | input | 1 | Store select: 0 block, 1 window |
| ld_addr | input | 10 | Pixel address, row-major |
| ld_data | input | 8 | Pixel value |
| start | input | 1 | Search launch pulse |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_sad | output | 16 | Lowest SAD found |
| mv_x | output | 4 | Horizontal offset of best match |
| mv_y | output | 4 | Vertical offset of best match |

## Verification
The search is run on seeded random pixel contents, compared against a software full search. A random window that holds an exact copy of the block must return SAD zero at the copy's offset, which shows that the addressing and the displacement are right. Two zero-SAD placements at (9,3) and (2,10) separate row-first from column-first tie handling. Uniform contents make all 256 candidates equal, so the result must be offset (0,0). The extreme case, a block of 255 against a window of 0, exposes a truncated accumulator. Extra start pulses during a search, a mid-search reset and writes after completion show that timing is not disturbed and that results hold.

// File: rtl/me_pkg.sv
package me_pkg;

    localparam int DEF_PIX_W = 8;
    localparam int DEF_BLK   = 16;
    localparam int DEF_OFF   = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_REDUCE,
        ST_FINISH
    } me_state_e;

endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
    parameter int PIX_W = 8,
    parameter int SAD_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] ref_px,
    input  logic [PIX_W-1:0] cand_px,
    output logic [SAD_W-1:0] acc
);

    logic [PIX_W-1:0] abs_diff;

    always_comb begin
        if (ref_px > cand_px) begin
            abs_diff = ref_px - cand_px;
        end else begin
            abs_diff = cand_px - ref_px;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + SAD_W'(abs_diff);
        end
    end

endmodule

// File: rtl/min_select.sv
module min_select #(
    parameter int N     = 16,
    parameter int SAD_W = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0][SAD_W-1:0] sads,
    output logic [SAD_W-1:0]        min_sad,
    output logic [IDX_W-1:0]        min_idx
);

    // Strict compare: the lowest index wins a tie.
    always_comb begin
        min_sad = sads[0];
        min_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (sads[i] < min_sad) begin
                min_sad = sads[i];
                min_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/best_tracker.sv
module best_tracker #(
    parameter int SAD_W = 16,
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             upd,
    input  logic [SAD_W-1:0] cand_sad,
    input  logic [OFF_W-1:0] cand_x,
    input  logic [OFF_W-1:0] cand_y,
    output logic [SAD_W-1:0] trk_sad,
    output logic [OFF_W-1:0] trk_x,
    output logic [OFF_W-1:0] trk_y
);

    // All-ones start value lies above any reachable SAD, so the
    // first pass always wins; the strict compare keeps earlier passes on ties.
    always_ff @(posedge clk) begin
        if (rst || init) begin
            trk_sad <= '1;
            trk_x   <= '0;
            trk_y   <= '0;
        end else if (upd && (cand_sad < trk_sad)) begin
            trk_sad <= cand_sad;
            trk_x   <= cand_x;
            trk_y   <= cand_y;
        end
    end

endmodule

// File: rtl/me_seq.sv
module me_seq
    import me_pkg::*;
#(
    parameter int BLK_W = 4,
    parameter int OFF_W = 4,
    parameter int OFF   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             trk_init,
    output logic             trk_upd,
    output logic             finish,
    output logic             busy,
    output logic [BLK_W-1:0] row,
    output logic [BLK_W-1:0] col,
    output logic [OFF_W-1:0] round
);

    localparam int PIX_CW = 2 * BLK_W;
    localparam logic [OFF_W-1:0] LAST_ROUND = OFF_W'(OFF - 1);

    me_state_e         state;
    me_state_e         nxt;
    logic [PIX_CW-1:0] pix;
    logic              last_pix;
    logic              last_round;

    assign last_pix   = (pix == {PIX_CW{1'b1}});
    assign last_round = (round == LAST_ROUND);
    assign row        = pix[PIX_CW-1:BLK_W];
    assign col        = pix[BLK_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_ACCUM;
            ST_ACCUM:  if (last_pix) nxt = ST_REDUCE;
            ST_REDUCE: nxt = last_round ? ST_FINISH : ST_ACCUM;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Pixel and pass counters
    always_ff @(posedge clk) begin
        if (rst) begin
            pix   <= '0;
            round <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    pix   <= '0;
                    round <= '0;
                end
                ST_ACCUM:  pix <= pix + 1'b1;
                ST_REDUCE: begin
                    pix <= '0;
                    if (!last_round) round <= round + 1'b1;
                end
                ST_FINISH: pix <= '0;
                default:   pix <= '0;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        acc_clr  = 1'b0;
        acc_en   = 1'b0;
        trk_init = 1'b0;
        trk_upd  = 1'b0;
        finish   = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                acc_clr  = 1'b1;
                trk_init = start;
            end
            ST_ACCUM:  acc_en = 1'b1;
            ST_REDUCE: begin
                trk_upd = 1'b1;
                acc_clr = 1'b1;
            end
            ST_FINISH: finish = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/sad_motion_search.sv
module sad_motion_search
    import me_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int BLK   = DEF_BLK,
    parameter int OFF   = DEF_OFF
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        ld_en,
    input  logic                                        ld_win,
    input  logic [$clog2((BLK+OFF-1)*(BLK+OFF-1))-1:0]  ld_addr,
    input  logic [PIX_W-1:0]                            ld_data,
    input  logic                                        start,
    output logic                                        busy,
    output logic                                        done,
    output logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] best_sad,
    output logic [$clog2(OFF)-1:0]                      mv_x,
    output logic [$clog2(OFF)-1:0]                      mv_y
);

    localparam int WIN    = BLK + OFF - 1;
    localparam int WIN_N  = WIN * WIN;
    localparam int BLK_N  = BLK * BLK;
    localparam int AW     = $clog2(WIN_N);
    localparam int BLK_W  = $clog2(BLK);
    localparam int BAW    = 2 * BLK_W;
    localparam int OFF_W  = $clog2(OFF);
    localparam int SAD_W  = $clog2(BLK_N * ((1 << PIX_W) - 1) + 1);

    logic [PIX_W-1:0] blk_mem [BLK_N];
    logic [PIX_W-1:0] win_mem [WIN_N];

    logic             acc_clr;
    logic             acc_en;
    logic             trk_init;
    logic             trk_upd;
    logic             finish;
    logic [BLK_W-1:0] row;
    logic [BLK_W-1:0] col;
    logic [OFF_W-1:0] round;

    logic [PIX_W-1:0]          ref_px;
    logic [OFF-1:0][SAD_W-1:0] pe_acc;
    logic [SAD_W-1:0]          pass_min;
    logic [OFF_W-1:0]          pass_idx;
    logic [SAD_W-1:0]          trk_sad;
    logic [OFF_W-1:0]          trk_x;
    logic [OFF_W-1:0]          trk_y;

    // Pixel loading: out-of-range addresses are dropped
    always_ff @(posedge clk) begin
        if (ld_en) begin
            if (ld_win) begin
                if (ld_addr < AW'(WIN_N)) win_mem[ld_addr] <= ld_data;
            end else begin
                if (ld_addr < AW'(BLK_N)) blk_mem[ld_addr[BAW-1:0]] <= ld_data;
            end
        end
    end

    me_seq #(
        .BLK_W (BLK_W),
        .OFF_W (OFF_W),
        .OFF   (OFF)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .acc_clr  (acc_clr),
        .acc_en   (acc_en),
        .trk_init (trk_init),
        .trk_upd  (trk_upd),
        .finish   (finish),
        .busy     (busy),
        .row      (row),
        .col      (col),
        .round    (round)
    );

    assign ref_px = blk_mem[{row, col}];

    // One processing element per horizontal offset
    for (genvar h = 0; h < OFF; h++) begin : g_pe
        logic [AW-1:0]    w_idx;
        logic [PIX_W-1:0] cand_px;

        assign w_idx   = AW'((int'(round) + int'(row)) * WIN + int'(col) + h);
        assign cand_px = win_mem[w_idx];

        sad_pe #(
            .PIX_W (PIX_W),
            .SAD_W (SAD_W)
        ) u_pe (
            .clk     (clk),
            .clr     (acc_clr),
            .en      (acc_en),
            .ref_px  (ref_px),
            .cand_px (cand_px),
            .acc     (pe_acc[h])
        );
    end

    min_select #(
        .N     (OFF),
        .SAD_W (SAD_W),
        .IDX_W (OFF_W)
    ) u_min (
        .sads    (pe_acc),
        .min_sad (pass_min),
        .min_idx (pass_idx)
    );

    best_tracker #(
        .SAD_W (SAD_W),
        .OFF_W (OFF_W)
    ) u_trk (
        .clk      (clk),
        .rst      (rst),
        .init     (trk_init),
        .upd      (trk_upd),
        .cand_sad (pass_min),
        .cand_x   (pass_idx),
        .cand_y   (round),
        .trk_sad  (trk_sad),
        .trk_x    (trk_x),
        .trk_y    (trk_y)
    );

    // Result latch and completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            best_sad <= '0;
            mv_x     <= '0;
            mv_y     <= '0;
            done     <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                best_sad <= trk_sad;
                mv_x     <= trk_x;
                mv_y     <= trk_y;
            end
        end
    end

endmodule

// File: rtl/me_search_chk.sv
module me_search_chk #(
    parameter int PIX_W = 8,
    parameter int BLK   = 16,
    parameter int OFF   = 16
) (
    input logic                                        clk,
    input logic                                        rst,
    input logic                                        start,
    input logic                                        busy,
    input logic                                        done,
    input logic [$clog2(BLK*BLK*((1<<PIX_W)-1)+1)-1:0] best_sad,
    input logic [$clog2(OFF)-1:0]                      mv_x,
    input logic [$clog2(OFF)-1:0]                      mv_y
);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_busy_ends_done_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> done);

    p_busy_held_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> (busy || done));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(best_sad) && $stable(mv_x) && $stable(mv_y)));

    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (!busy && !done && best_sad == '0 && mv_x == '0 && mv_y == '0));

endmodule

bind sad_motion_search me_search_chk #(
    .PIX_W (PIX_W),
    .BLK   (BLK),
    .OFF   (OFF)
) u_me_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .best_sad (best_sad),
    .mv_x     (mv_x),
    .mv_y     (mv_y)
);

// File: tb/test_sad_motion_search.sv
module test_sad_motion_search;

    localparam int BLK     = 16;
    localparam int OFF     = 16;
    localparam int WIN     = BLK + OFF - 1;
    localparam int LATENCY = OFF * (BLK * BLK + 1) + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic       ld_win = 1'b0;
    logic [9:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       start = 1'b0;
    logic       busy;
    logic       done;
    logic [15:0] best_sad;
    logic [3:0]  mv_x;
    logic [3:0]  mv_y;

    int n_chk = 0;
    int n_bad = 0;
    int seed_dummy;

    logic [7:0] bm [BLK*BLK];
    logic [7:0] wm [WIN*WIN];
    int exp_sad, exp_x, exp_y;

    always #4 clk = ~clk;

    sad_motion_search i_sad_motion_search (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_win(ld_win),
        .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
        .busy(busy), .done(done), .best_sad(best_sad),
        .mv_x(mv_x), .mv_y(mv_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int addr, input int val);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_win  = sel;
        ld_addr = 10'(addr);
        ld_data = 8'(val);
    endtask

    task automatic load_all();
        for (int i = 0; i < BLK*BLK; i++) wr(1'b0, i, int'(bm[i]));
        for (int i = 0; i < WIN*WIN; i++) wr(1'b1, i, int'(wm[i]));
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Software full search, raster order with strict compare
    task automatic model();
        exp_sad = 1 << 30;
        for (int y = 0; y < OFF; y++) begin
            for (int x = 0; x < OFF; x++) begin
                int s = 0;
                for (int r = 0; r < BLK; r++) begin
                    for (int c = 0; c < BLK; c++) begin
                        int a = int'(bm[r*BLK+c]);
                        int b = int'(wm[(y+r)*WIN + x + c]);
                        s += (a > b) ? a - b : b - a;
                    end
                end
                if (s < exp_sad) begin
                    exp_sad = s; exp_x = x; exp_y = y;
                end
            end
        end
    endtask

    // Launch, optionally re-pulse start mid-run, check latency, pulse and result
    task automatic run(input string tag, input bit extra_start);
        int cnt = 0;
        bit seen = 0;
        int prev_sad = int'(best_sad);
        model();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R6 busy after start"}, int'(busy), 1);
        while (cnt < LATENCY + 50) begin
            if (done) begin seen = 1; break; end
            if (extra_start && cnt == 1000) begin
                start = 1'b1;
                chk({tag, " R7 result held mid-run"}, int'(best_sad), prev_sad);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        start = 1'b0;
        chk({tag, " R6 done seen"}, int'(seen), 1);
        chk({tag, extra_start ? " R8 latency" : " R6 latency"}, cnt, LATENCY);
        chk({tag, " R6 busy low at done"}, int'(busy), 0);
        chk({tag, " R2 sad"}, int'(best_sad), exp_sad);
        chk({tag, " R4 mv_x"}, int'(mv_x), exp_x);
        chk({tag, " R4 mv_y"}, int'(mv_y), exp_y);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, int'(done), 0);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < BLK*BLK; i++) bm[i] = 8'($urandom);
        for (int i = 0; i < WIN*WIN; i++) wm[i] = 8'($urandom);
    endtask

    task automatic place_copy(input int x, input int y);
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < BLK; c++)
                wm[(y+r)*WIN + x + c] = bm[r*BLK+c];
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset sad", int'(best_sad), 0);
        chk("R9 reset mv", int'({mv_y, mv_x}), 0);

        // Random contents
        for (int k = 0; k < 2; k++) begin
            fill_rand();
            load_all();
            run("random R2", 1'b0);
        end

        // Exact copy plus an out-of-range block write (R1)
        fill_rand();
        place_copy(7, 11);
        load_all();
        wr(1'b0, 256 + 44, 8'hAB);
        wr(1'b1, 1000, 8'hAB);
        @(negedge clk);
        ld_en = 1'b0;
        run("copy R1", 1'b0);
        chk("R1 copy sad zero", int'(best_sad), 0);
        chk("R1 copy offset", int'({mv_y, mv_x}), (11 << 4) | 7);

        // Tie: zero-SAD at (9,3) and (2,10); row-first gives (9,3)
        for (int i = 0; i < BLK*BLK; i++) bm[i] = 8'd10;
        for (int i = 0; i < WIN*WIN; i++) wm[i] = 8'd200;
        place_copy(9, 3);
        place_copy(2, 10);
        load_all();
        run("tie R5", 1'b0);
        chk("R5 tie x", int'(mv_x), 9);
        chk("R5 tie y", int'(mv_y), 3);

        // Uniform: every candidate equal, first one wins
        for (int i = 0; i < BLK*BLK; i++) bm[i] = 8'd0;
        for (int i = 0; i < WIN*WIN; i++) wm[i] = 8'd1;
        load_all();
        run("uniform R5", 1'b0);
        chk("R5 uniform sad", int'(best_sad), 256);
        chk("R5 uniform offset", int'({mv_y, mv_x}), 0);

        // Largest SAD
        for (int i = 0; i < BLK*BLK; i++) bm[i] = 8'd255;
        for (int i = 0; i < WIN*WIN; i++) wm[i] = 8'd0;
        load_all();
        run("max R3", 1'b0);
        chk("R3 max sad", int'(best_sad), 65280);

        // Hold after done while memories are rewritten
        for (int i = 0; i < 40; i++) wr(1'b1, i, 8'd255);
        @(negedge clk);
        ld_en = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 hold sad", int'(best_sad), 65280);
        chk("R7 hold mv", int'({mv_y, mv_x}), 0);
        for (int i = 0; i < 40; i++) wm[i] = 8'd255;

        // Start re-pulsed while busy
        fill_rand();
        load_all();
        run("restart R8", 1'b1);

        // Reset in the middle of a search
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (500) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 midrun busy", int'(busy), 0);
        chk("R9 midrun sad", int'(best_sad), 0);
        begin
            bit late = 0;
            for (int i = 0; i < LATENCY; i++) begin
                @(negedge clk);
                if (done) late = 1;
            end
            chk("R9 no done after reset", int'(late), 0);
        end
        run("after reset R9", 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule